// File: doc/BRIEF.md
# Grouped Signaling Input Debouncer

This block watches a small group of asynchronous signaling lines that belong to one channel pair. It brings them into the system clock domain and looks at the whole group once per sampling interval. The interval is set by a programmable field and counted in pulses of a reference-rate enable, 1536 per millisecond by default. The group is accepted only when two consecutive samples agree on every line. The accepted value is then held in a readable register, and a level interrupt tells the controller that a new signaling state has arrived.

The system clock runs freely. The reference-rate enable stands for the slow reference clock. While that enable stays low, no sampling, acceptance or interrupt setting takes place. The first stable value after reset seeds the register and raises no interrupt. After that, an interrupt is raised only when a newly accepted value differs from the one already held. The interrupt stays high until an acknowledge strobe clears it.

Top module: `sdb_debounce`

## Requirements
- R1: While reset is asserted (rst_n low), sig_reg is all zeros and irq is 0.
- R2: While ref_en is low, sig_reg and the pending state of irq stay unchanged, whatever sig_in does. Only ack can still clear irq.
- R3: A sample is taken once every (ivl+1)*CYC_PER_MS ref_en pulses. ivl is an unsigned 4-bit field by default. Each input passes a two-flop synchroniser first, so a steady change appears on sig_reg between P+3 and 2P+2 clock cycles after it is applied, where P is the sampling period in clock cycles.
- R4: The first value that is stable over two samples after reset is loaded into sig_reg, and irq stays 0.
- R5: A value is accepted only when all NUM_IN lines match across two successive samples. A pulse shorter than one sampling period never reaches sig_reg.
- R6: When an accepted value differs from sig_reg, sig_reg takes it and irq goes to 1 on the same clock edge. irq then stays 1 until acknowledged.
- R7: A one-cycle ack with no new accepted change clears irq on the next clock edge.
- R8: If a new accepted change and ack occur on the same edge, irq is 1 after that edge.
- R9: An accepted value equal to sig_reg raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One pulse per reference-clock period; low means the reference is stopped |
| ivl | input | IVL_W | Sampling interval field, period is ivl+1 ms |
| ack | input | 1 | Interrupt acknowledge strobe |
| sig_in | input | NUM_IN | Raw asynchronous signaling lines |
| sig_reg | output | NUM_IN | Last accepted signaling state |
| irq | output | 1 | Signaling-change interrupt, level high |

## Verification
Some properties are checked on every cycle by assertions. The register may move only on a sampling tick. Nothing moves while the reference enable is low. An interrupt rise always comes with a changed register value. The interrupt holds until acknowledged, an acknowledge clears it, and a change wins over an acknowledge in the same cycle. Other behaviour can only be shown by the bench scenarios. These are the timing window that follows from the interval field, the rejection of short glitches, the staggered change of several lines, the silent seeding after reset, and the catch-up once the reference enable resumes.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
   function automatic int sdb_cw(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/sdb_sync.sv
module sdb_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sdb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/sdb_tick.sv
module sdb_tick #(
   parameter int CYC_PER_MS = 1536,
   parameter int IVL_W      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_en,
   input  logic [IVL_W-1:0] ivl,
   output logic             tick
);
   import sdb_pkg::*;
   localparam int CW = sdb_cw(CYC_PER_MS);

   if (CYC_PER_MS < 1) begin : g_bad_cyc
      $error("sdb_tick: CYC_PER_MS must be at least 1");
   end

   logic             cyc_last;
   logic [IVL_W-1:0] ms_cnt;

   if (CYC_PER_MS == 1) begin : g_direct
      assign cyc_last = 1'b1;
   end else begin : g_count
      logic [CW-1:0] cyc_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                cyc_cnt <= '0;
         else if (ref_en && cyc_last) cyc_cnt <= '0;
         else if (ref_en)           cyc_cnt <= cyc_cnt + 1'b1;
      end
      assign cyc_last = (cyc_cnt == CW'(CYC_PER_MS - 1));

      // R3: sampling ticks are at least one reference period apart
      p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    ms_cnt <= '0;
      else if (ref_en && cyc_last) begin
         if (ms_cnt >= ivl)          ms_cnt <= '0;
         else                        ms_cnt <= ms_cnt + 1'b1;
      end
   end

   assign tick = ref_en && cyc_last && (ms_cnt >= ivl);
endmodule

// File: rtl/sdb_stab.sv
module sdb_stab #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] samp,
   input  logic         ack,
   output logic [W-1:0] sig_q,
   output logic         irq
);
   logic [W-1:0] prev;
   logic         have_prev;
   logic         seeded;
   logic         accept;
   logic         chg;

   assign accept = tick && have_prev && (samp == prev);
   assign chg    = accept && seeded && (samp != sig_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev      <= '0;
         have_prev <= 1'b0;
      end else if (tick) begin
         prev      <= samp;
         have_prev <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sig_q  <= '0;
         seeded <= 1'b0;
      end else if (accept) begin
         sig_q  <= samp;
         seeded <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   irq <= 1'b0;
      else if (chg) irq <= 1'b1;
      else if (ack) irq <= 1'b0;
   end

   // R3 / R5: the held value only moves on a sampling tick
   p_update_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(sig_q));
   // R6: a pending interrupt holds without an acknowledge
   p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack) |=> irq);
   // R7: acknowledge clears when no change arrives
   p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !chg) |=> !irq);
   // R8: a change beats a simultaneous acknowledge
   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> irq);
endmodule

// File: rtl/sdb_debounce.sv
module sdb_debounce #(
   parameter int NUM_IN      = 4,
   parameter int CYC_PER_MS  = 1536,
   parameter int IVL_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_en,
   input  logic [IVL_W-1:0]  ivl,
   input  logic              ack,
   input  logic [NUM_IN-1:0] sig_in,
   output logic [NUM_IN-1:0] sig_reg,
   output logic              irq
);
   if (NUM_IN < 1) begin : g_bad_width
      $error("sdb_debounce: NUM_IN must be at least 1");
   end
   if (IVL_W < 1) begin : g_bad_ivl
      $error("sdb_debounce: IVL_W must be at least 1");
   end

   logic [NUM_IN-1:0] sync_q;
   logic              tick;

   sdb_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(sig_in), .q(sync_q));

   sdb_tick #(.CYC_PER_MS(CYC_PER_MS), .IVL_W(IVL_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .ivl(ivl), .tick(tick));

   sdb_stab #(.W(NUM_IN)) u_stab (
      .clk(clk), .rst_n(rst_n), .tick(tick), .samp(sync_q), .ack(ack),
      .sig_q(sig_reg), .irq(irq));

   // R2: a stopped reference freezes the register and blocks new interrupts
   p_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_en |=> ($stable(sig_reg) && !$rose(irq)));
   // R9: an interrupt only rises together with a changed value
   p_rise_needs_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (sig_reg != $past(sig_reg)));
endmodule

// File: tb/sdb_debounce_bench.sv
module sdb_debounce_bench;
   localparam int NI  = 4;
   localparam int CPM = 8;

   typedef struct {
      logic [NI-1:0] v;
      logic          ir;
      int            lo;
      int            hi;
      int            t0;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ref_en = 1'b1;
   logic [3:0]    ivl = 4'd0;
   logic          ack = 1'b0;
   logic [NI-1:0] sig_in = 4'hA;
   logic [NI-1:0] sig_reg;
   logic          irq;

   int    n_chk = 0;
   int    n_bad = 0;
   int    cyc = 0;
   bit    done = 1'b0;
   item_t sb[$];
   logic [NI-1:0] last_seen = '0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sdb_debounce #(.NUM_IN(NI), .CYC_PER_MS(CPM), .IVL_W(4)) u_sdb_debounce (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .ivl(ivl), .ack(ack),
      .sig_in(sig_in), .sig_reg(sig_reg), .irq(irq));

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic expect_upd(input logic [NI-1:0] v, input logic ir,
                             input int lo, input int hi);
      item_t it;
      it.v = v; it.ir = ir; it.lo = lo; it.hi = hi; it.t0 = cyc;
      sb.push_back(it);
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: every register update is matched against the scoreboard
   always @(negedge clk) begin
      if (rst_n && sig_reg !== last_seen) begin
         if (sb.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R5: unexpected update actual %0h expected %0h",
                     sig_reg, last_seen);
         end else begin
            item_t it;
            int d;
            it = sb.pop_front();
            d = cyc - it.t0;
            check("R6 value", sig_reg, it.v);
            check("R6/R4/R8 irq", irq, it.ir);
            n_chk++;
            if (d < it.lo || d > it.hi) begin
               n_bad++;
               $display("FAIL R3: delay actual %0d expected %0d..%0d",
                        d, it.lo, it.hi);
            end
         end
         last_seen = sig_reg;
      end
   end

   initial begin
      // R1: reset state
      wait_n(3);
      check("R1 sig_reg", sig_reg, 0);
      check("R1 irq", irq, 0);
      // R4: seeding after reset, ivl=0 (P=8)
      expect_upd(4'hA, 1'b0, 1, 20);
      rst_n = 1'b1;
      wait_n(60);
      check("R4 seeded", sig_reg, 4'hA);
      check("R4 no irq", irq, 0);

      // R6: change with ivl=0, window [P+1, 2P+4] = [9,20]
      expect_upd(4'h5, 1'b1, 9, 20);
      sig_in = 4'h5;
      wait_n(40);
      check("R6 hold", irq, 1);
      ack = 1'b1;
      wait_n(1);
      ack = 1'b0;
      check("R7 cleared", irq, 0);

      // R3: longer interval ivl=3 (P=32), window [33,68]
      ivl = 4'd3;
      wait_n(80);
      expect_upd(4'h3, 1'b1, 33, 68);
      sig_in = 4'h3;
      wait_n(100);
      ack = 1'b1;
      wait_n(1);
      ack = 1'b0;

      // R5: glitch shorter than one period is rejected
      sig_in = 4'hC;
      wait_n(10);
      sig_in = 4'h3;
      wait_n(150);
      check("R5 glitch reg", sig_reg, 4'h3);
      // R9: stable unchanged value gives no interrupt
      check("R9 no irq", irq, 0);

      // R2: stopped reference freezes everything
      ref_en = 1'b0;
      sig_in = 4'h6;
      wait_n(300);
      check("R2 frozen", sig_reg, 4'h3);
      check("R2 irq", irq, 0);
      expect_upd(4'h6, 1'b1, 1, 70);
      ref_en = 1'b1;
      wait_n(100);
      ack = 1'b1;
      wait_n(1);
      ack = 1'b0;

      // R8: acknowledge held high across the update edge
      ivl = 4'd0;
      wait_n(80);
      ack = 1'b1;
      expect_upd(4'h9, 1'b1, 9, 20);
      sig_in = 4'h9;
      wait_n(30);
      check("R8 cleared after", irq, 0);
      ack = 1'b0;

      // R5: staggered lines, only the final group value is accepted
      sig_in = 4'hB;
      wait_n(2);
      expect_upd(4'hF, 1'b1, 9, 20);
      sig_in = 4'hF;
      wait_n(40);
      check("R5 group", sig_reg, 4'hF);
      check("R5 pending", sb.size(), 0);
      done = 1'b1;
   end

   initial begin
      int w;
      w = 0;
      while (!done && w < 20000) begin
         @(posedge clk);
         w++;
      end
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule